// File: doc/BRIEF.md
# Coupled Lateral/Vertical Flight Mode Pair

This block runs two small flight-guidance mode machines on one clock and in lockstep. One chooses the lateral mode and the other the vertical mode. Each machine reacts to pilot switch presses, to capture signals and to a change of the coupled side. Each one also watches the other machine's mode.

The lateral result for a cycle goes to the vertical machine in that same cycle. The vertical mode goes back to the lateral machine only through a register, and this register breaks the combinational loop between the two machines. The ordering keeps two couplings in step: vertical approach is held only under lateral approach, and the two go-around modes agree.

A `quiet` output is high in every cycle in which no input event occurs. Surrounding logic can use it to tell when the pair has settled.

An event is a rising edge of a switch or capture input, or any change of the coupled-side input. Inputs are compared with their values at the previous clock edge. When several events apply to the current mode, the highest-priority one wins.

Top module: `mode_pair_top`

## Requirements
- R1: Reset (synchronous, active low) puts the lateral mode at ROLL and the vertical mode at PITCH. The codes on the mode outputs are: lateral ROLL=0, HDG=1, APPR=2, GA=3; vertical PITCH=0, SPEED=1, APPR=2, GA=3. A switch held high through reset gives no event after release.
- R2: Lateral machine. In ROLL a heading press goes to HDG, and in HDG a heading press goes to ROLL. A go-around press beats a heading press in the same cycle.
- R3: In lateral APPR a heading press moves to HDG only when the vertical mode is not APPR. Otherwise the press is ignored.
- R4: Vertical machine. A speed press toggles PITCH to SPEED and SPEED to PITCH. From APPR or GA a speed press goes to SPEED.
- R5: A rising edge on the vertical capture input enters vertical APPR from PITCH or SPEED only when the lateral mode in that same cycle (after its own update) is APPR. This includes a lateral capture in the same cycle.
- R6: Vertical APPR is only ever seen together with lateral APPR. The vertical machine leaves APPR in the same cycle the lateral machine leaves it.
- R7: A go-around press from ROLL/PITCH (or from APPR/APPR) puts both machines in GA in the same cycle.
- R8: A speed press while both are in GA moves the vertical machine to SPEED. The lateral machine leaves GA for ROLL one cycle later, without any further input.
- R9: A sync press in GA/GA returns both machines to ROLL/PITCH in the same cycle.
- R10: A change of the coupled-side input in either direction sends HDG, APPR and GA to ROLL (lateral), and SPEED, APPR and GA to PITCH (vertical).
- R11: `quiet_o` is low exactly in the cycles with an input event. Switch releases are not events.
- R12: If lateral GA and vertical GA disagree in a quiet cycle, they agree on the next cycle.
- R13: After two quiet cycles in a row, neither mode changes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| side_i | input | 1 | Coupled-side selection; any change is an event |
| hdg_sw_i | input | 1 | Heading switch |
| spd_sw_i | input | 1 | Speed switch |
| sync_sw_i | input | 1 | Sync switch |
| ga_sw_i | input | 1 | Go-around switch |
| lat_cap_i | input | 1 | Lateral approach capture |
| ver_cap_i | input | 1 | Vertical approach capture |
| lat_mode_o | output | 2 | Lateral mode code |
| ver_mode_o | output | 2 | Vertical mode code |
| quiet_o | output | 1 | No input event in this cycle |

## Verification
The hardest state to reach is a go-around disagreement caused by the vertical machine. To get there, first bring the pair into GA/GA. Then press speed, which leaves lateral GA waiting one cycle on the register. In that one cycle, press go-around again: the lateral machine drops to ROLL while the vertical machine re-enters GA. The bench then checks that a single quiet cycle pulls the lateral machine back into GA and that the pair then stays put. A heading press is also tried while both machines hold APPR, to confirm that the interlock guard blocks it.

// File: rtl/mode_pair_pkg.sv
package mode_pair_pkg;

    typedef enum logic [1:0] {
        LAT_ROLL = 2'd0,
        LAT_HDG  = 2'd1,
        LAT_APPR = 2'd2,
        LAT_GA   = 2'd3
    } lat_mode_e;

    typedef enum logic [1:0] {
        VER_PITCH = 2'd0,
        VER_SPD   = 2'd1,
        VER_APPR  = 2'd2,
        VER_GA    = 2'd3
    } ver_mode_e;

    // edge-detected switch lines, bit positions inside the detector vector
    localparam int unsigned SW_HDG   = 0;
    localparam int unsigned SW_SPD   = 1;
    localparam int unsigned SW_SYNC  = 2;
    localparam int unsigned SW_GA    = 3;
    localparam int unsigned SW_LCAP  = 4;
    localparam int unsigned SW_VCAP  = 5;
    localparam int unsigned SW_COUNT = 6;

    typedef struct packed {
        logic hdg;
        logic spd;
        logic sync;
        logic ga;
        logic lcap;
        logic vcap;
        logic side;
    } pair_evt_t;

    typedef struct packed {
        lat_mode_e lat;
        ver_mode_e ver;
        ver_mode_e ver_dly;
    } pair_state_t;

endpackage

// File: rtl/mp_event_detect.sv
module mp_event_detect #(
    parameter int unsigned N_SW = 6
) (
    input  logic            clk,
    input  logic [N_SW-1:0] sw_i,
    input  logic            side_i,
    output logic [N_SW-1:0] rise_o,
    output logic            side_chg_o,
    output logic            quiet_o
);
    logic [N_SW-1:0] prev_d, prev_q;
    logic            side_d, side_q;

    // previous-sample registers follow the pins in and out of reset, so a
    // switch held through reset produces no edge afterwards
    always_comb begin
        prev_d = sw_i;
        side_d = side_i;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
        side_q <= side_d;
    end

    for (genvar i = 0; i < N_SW; i++) begin : g_rise
        assign rise_o[i] = sw_i[i] & ~prev_q[i];
    end

    assign side_chg_o = side_i ^ side_q;
    assign quiet_o    = ~(|rise_o) & ~side_chg_o;

endmodule

// File: rtl/mp_lat_next.sv
module mp_lat_next
    import mode_pair_pkg::*;
(
    input  lat_mode_e cur_i,
    input  logic      hdg_i,
    input  logic      sync_i,
    input  logic      ga_i,
    input  logic      cap_i,
    input  logic      side_i,
    input  ver_mode_e ver_now_i,
    input  ver_mode_e ver_dly_i,
    output lat_mode_e nxt_o
);
    logic ver_into_ga, ver_out_of_ga;

    // vertical mode seen only through its register and a delayed copy
    assign ver_into_ga   = (ver_now_i == VER_GA) && (ver_dly_i != VER_GA);
    assign ver_out_of_ga = (ver_now_i != VER_GA) && (ver_dly_i == VER_GA);

    // per source mode, applicable events from highest to lowest priority
    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            LAT_ROLL: begin
                if (ver_into_ga || ga_i) nxt_o = LAT_GA;
                else if (hdg_i)          nxt_o = LAT_HDG;
                else if (cap_i)          nxt_o = LAT_APPR;
            end
            LAT_HDG: begin
                if (ver_into_ga || ga_i) nxt_o = LAT_GA;
                else if (hdg_i)          nxt_o = LAT_ROLL;
                else if (cap_i)          nxt_o = LAT_APPR;
                else if (side_i)         nxt_o = LAT_ROLL;
            end
            LAT_APPR: begin
                if (ver_into_ga || ga_i)                 nxt_o = LAT_GA;
                else if (hdg_i && ver_now_i != VER_APPR) nxt_o = LAT_HDG;
                else if (side_i)                         nxt_o = LAT_ROLL;
            end
            LAT_GA: begin
                if (ver_out_of_ga || sync_i) nxt_o = LAT_ROLL;
                else if (hdg_i)              nxt_o = LAT_HDG;
                else if (side_i)             nxt_o = LAT_ROLL;
            end
            default: nxt_o = LAT_ROLL;
        endcase
    end

endmodule

// File: rtl/mp_ver_next.sv
module mp_ver_next
    import mode_pair_pkg::*;
(
    input  ver_mode_e cur_i,
    input  logic      spd_i,
    input  logic      sync_i,
    input  logic      ga_i,
    input  logic      cap_i,
    input  logic      side_i,
    input  lat_mode_e lat_now_i,
    input  lat_mode_e lat_nxt_i,
    output ver_mode_e nxt_o
);
    logic lat_into_ga, lat_out_of_ga, lat_out_of_appr, cap_ok;

    // lateral result of this same cycle is visible here
    assign lat_into_ga     = (lat_nxt_i == LAT_GA) && (lat_now_i != LAT_GA);
    assign lat_out_of_ga   = (lat_nxt_i != LAT_GA) && (lat_now_i == LAT_GA);
    assign lat_out_of_appr = (lat_nxt_i != LAT_APPR) && (lat_now_i == LAT_APPR);
    assign cap_ok          = cap_i && (lat_nxt_i == LAT_APPR);

    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            VER_PITCH: begin
                if (lat_into_ga || ga_i) nxt_o = VER_GA;
                else if (spd_i)          nxt_o = VER_SPD;
                else if (cap_ok)         nxt_o = VER_APPR;
            end
            VER_SPD: begin
                if (lat_into_ga || ga_i) nxt_o = VER_GA;
                else if (spd_i)          nxt_o = VER_PITCH;
                else if (cap_ok)         nxt_o = VER_APPR;
                else if (side_i)         nxt_o = VER_PITCH;
            end
            VER_APPR: begin
                if (lat_into_ga || ga_i)             nxt_o = VER_GA;
                else if (spd_i)                      nxt_o = VER_SPD;
                else if (lat_out_of_appr || side_i)  nxt_o = VER_PITCH;
            end
            VER_GA: begin
                if (lat_out_of_ga || sync_i) nxt_o = VER_PITCH;
                else if (spd_i)              nxt_o = VER_SPD;
                else if (side_i)             nxt_o = VER_PITCH;
            end
            default: nxt_o = VER_PITCH;
        endcase
    end

endmodule

// File: rtl/mode_pair_top.sv
module mode_pair_top
    import mode_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       side_i,
    input  logic       hdg_sw_i,
    input  logic       spd_sw_i,
    input  logic       sync_sw_i,
    input  logic       ga_sw_i,
    input  logic       lat_cap_i,
    input  logic       ver_cap_i,
    output logic [1:0] lat_mode_o,
    output logic [1:0] ver_mode_o,
    output logic       quiet_o
);
    logic [SW_COUNT-1:0] sw_vec, sw_rise;
    logic                side_chg;
    pair_evt_t           evt;
    pair_state_t         st_d, st_q;
    lat_mode_e           lat_nxt;
    ver_mode_e           ver_nxt;

    always_comb begin
        sw_vec          = '0;
        sw_vec[SW_HDG]  = hdg_sw_i;
        sw_vec[SW_SPD]  = spd_sw_i;
        sw_vec[SW_SYNC] = sync_sw_i;
        sw_vec[SW_GA]   = ga_sw_i;
        sw_vec[SW_LCAP] = lat_cap_i;
        sw_vec[SW_VCAP] = ver_cap_i;
    end

    mp_event_detect #(.N_SW(SW_COUNT)) u_evt (
        .clk        (clk),
        .sw_i       (sw_vec),
        .side_i     (side_i),
        .rise_o     (sw_rise),
        .side_chg_o (side_chg),
        .quiet_o    (quiet_o)
    );

    always_comb begin
        evt.hdg  = sw_rise[SW_HDG];
        evt.spd  = sw_rise[SW_SPD];
        evt.sync = sw_rise[SW_SYNC];
        evt.ga   = sw_rise[SW_GA];
        evt.lcap = sw_rise[SW_LCAP];
        evt.vcap = sw_rise[SW_VCAP];
        evt.side = side_chg;
    end

    mp_lat_next u_lat (
        .cur_i     (st_q.lat),
        .hdg_i     (evt.hdg),
        .sync_i    (evt.sync),
        .ga_i      (evt.ga),
        .cap_i     (evt.lcap),
        .side_i    (evt.side),
        .ver_now_i (st_q.ver),
        .ver_dly_i (st_q.ver_dly),
        .nxt_o     (lat_nxt)
    );

    mp_ver_next u_ver (
        .cur_i     (st_q.ver),
        .spd_i     (evt.spd),
        .sync_i    (evt.sync),
        .ga_i      (evt.ga),
        .cap_i     (evt.vcap),
        .side_i    (evt.side),
        .lat_now_i (st_q.lat),
        .lat_nxt_i (lat_nxt),
        .nxt_o     (ver_nxt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.lat     = lat_nxt;
        st_d.ver     = ver_nxt;
        st_d.ver_dly = st_q.ver;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lat     <= LAT_ROLL;
            st_q.ver     <= VER_PITCH;
            st_q.ver_dly <= VER_PITCH;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_mode_o = st_q.lat;
    assign ver_mode_o = st_q.ver;

    // R1
    a_r1_reset_modes: assert property (@(posedge clk)
        !rst_n |=> (lat_mode_o == 2'd0 && ver_mode_o == 2'd0));

    // R6
    a_r6_appr_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ver == VER_APPR) |-> (st_q.lat == LAT_APPR));

    // R7
    a_r7_ga_joint: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.ga && st_q.lat == LAT_ROLL && st_q.ver == VER_PITCH)
        |=> (lat_mode_o == 2'd3 && ver_mode_o == 2'd3));

    // R11
    a_r11_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(side_i) || $rose(hdg_sw_i) || $rose(spd_sw_i) || $rose(sync_sw_i)
         || $rose(ga_sw_i) || $rose(lat_cap_i) || $rose(ver_cap_i)) |-> !quiet_o);

    // R12
    a_r12_ga_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_o && ((lat_mode_o == 2'd3) != (ver_mode_o == 2'd3)))
        |=> ((lat_mode_o == 2'd3) == (ver_mode_o == 2'd3)));

    // R13
    a_r13_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_o && $past(quiet_o)) |=> ($stable(lat_mode_o) && $stable(ver_mode_o)));

endmodule

// File: tb/tb_mode_pair_top.sv
module tb_mode_pair_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n, side, hdg, spd, sync, ga, lcap, vcap;
    logic [1:0] lat_mode, ver_mode;
    logic quiet;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mode_pair_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .side_i     (side),
        .hdg_sw_i   (hdg),
        .spd_sw_i   (spd),
        .sync_sw_i  (sync),
        .ga_sw_i    (ga),
        .lat_cap_i  (lcap),
        .ver_cap_i  (vcap),
        .lat_mode_o (lat_mode),
        .ver_mode_o (ver_mode),
        .quiet_o    (quiet)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // drive switches, check quiet before the edge, modes after it
    task automatic cyc(input logic h, input logic s, input logic y, input logic g,
                       input logic lc, input logic vc, input logic exp_q,
                       input int el, input int ev, input string req);
        hdg = h; spd = s; sync = y; ga = g; lcap = lc; vcap = vc;
        #1;
        chk(req, "quiet", int'(quiet), int'(exp_q));
        tick();
        chk(req, "lat", int'(lat_mode), el);
        chk(req, "ver", int'(ver_mode), ev);
    endtask

    task automatic idle(input int el, input int ev, input string req);
        cyc(0, 0, 0, 0, 0, 0, 1'b1, el, ev, req);
    endtask

    task automatic flip_side(input int el, input int ev, input string req);
        side = ~side;
        #1;
        chk(req, "quiet", int'(quiet), 0);
        tick();
        chk(req, "lat", int'(lat_mode), el);
        chk(req, "ver", int'(ver_mode), ev);
    endtask

    task automatic t_reset();  // R1, R11
        rst_n = 1'b0; side = 1'b0; hdg = 0; spd = 0; sync = 0; ga = 1'b1; lcap = 0; vcap = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        chk("R1", "lat", int'(lat_mode), 0);
        chk("R1", "ver", int'(ver_mode), 0);
        chk("R11", "quiet held sw", int'(quiet), 1);
        tick();
        chk("R1", "lat held ga", int'(lat_mode), 0);
        idle(0, 0, "R11");
    endtask

    task automatic t_hdg();  // R2
        cyc(1, 0, 0, 0, 0, 0, 1'b0, 1, 0, "R2");
        idle(1, 0, "R2");
        cyc(1, 0, 0, 0, 0, 0, 1'b0, 0, 0, "R2");
        idle(0, 0, "R2");
    endtask

    task automatic t_ga_priority();  // R2 R7 R9
        cyc(1, 0, 0, 1, 0, 0, 1'b0, 3, 3, "R7");
        idle(3, 3, "R13");
        cyc(0, 0, 1, 0, 0, 0, 1'b0, 0, 0, "R9");
        idle(0, 0, "R9");
    endtask

    task automatic t_spd();  // R4
        cyc(0, 1, 0, 0, 0, 0, 1'b0, 0, 1, "R4");
        idle(0, 1, "R4");
        cyc(0, 1, 0, 0, 0, 0, 1'b0, 0, 0, "R4");
        idle(0, 0, "R4");
    endtask

    task automatic t_spd_in_ga();  // R8 R12 R13
        cyc(0, 0, 0, 1, 0, 0, 1'b0, 3, 3, "R7");
        idle(3, 3, "R8");
        cyc(0, 1, 0, 0, 0, 0, 1'b0, 3, 1, "R8");
        idle(0, 1, "R12");
        idle(0, 1, "R13");
        cyc(0, 1, 0, 0, 0, 0, 1'b0, 0, 0, "R4");
        idle(0, 0, "R4");
    endtask

    task automatic t_capture();  // R5 R3 R6 R10
        cyc(0, 0, 0, 0, 0, 1, 1'b0, 0, 0, "R5");
        idle(0, 0, "R5");
        cyc(0, 0, 0, 0, 1, 1, 1'b0, 2, 2, "R5");
        idle(2, 2, "R5");
        cyc(1, 0, 0, 0, 0, 0, 1'b0, 2, 2, "R3");
        idle(2, 2, "R3");
        flip_side(0, 0, "R6");
        idle(0, 0, "R10");
    endtask

    task automatic t_hdg_from_appr();  // R3
        cyc(0, 0, 0, 0, 1, 0, 1'b0, 2, 0, "R3");
        idle(2, 0, "R3");
        cyc(1, 0, 0, 0, 0, 0, 1'b0, 1, 0, "R3");
        idle(1, 0, "R3");
        cyc(1, 0, 0, 0, 0, 0, 1'b0, 0, 0, "R2");
        idle(0, 0, "R2");
    endtask

    task automatic t_appr_to_ga();  // R6 R7
        cyc(0, 0, 0, 0, 1, 0, 1'b0, 2, 0, "R5");
        cyc(0, 0, 0, 0, 0, 1, 1'b0, 2, 2, "R5");
        idle(2, 2, "R6");
        cyc(0, 0, 0, 1, 0, 0, 1'b0, 3, 3, "R7");
        idle(3, 3, "R7");
        cyc(0, 0, 1, 0, 0, 0, 1'b0, 0, 0, "R9");
        idle(0, 0, "R9");
    endtask

    task automatic t_side_back();  // R10
        cyc(0, 1, 0, 0, 0, 0, 1'b0, 0, 1, "R4");
        cyc(1, 0, 0, 0, 0, 0, 1'b0, 1, 1, "R2");
        idle(1, 1, "R10");
        flip_side(0, 0, "R10");
        idle(0, 0, "R10");
    endtask

    task automatic t_ga_after_spd();  // R12 R13
        cyc(0, 0, 0, 1, 0, 0, 1'b0, 3, 3, "R7");
        idle(3, 3, "R12");
        cyc(0, 1, 0, 0, 0, 0, 1'b0, 3, 1, "R8");
        cyc(0, 0, 0, 1, 0, 0, 1'b0, 0, 3, "R12");
        idle(3, 3, "R12");
        idle(3, 3, "R13");
        cyc(0, 0, 1, 0, 0, 0, 1'b0, 0, 0, "R9");
        idle(0, 0, "R9");
    endtask

    initial begin
        t_reset();
        t_hdg();
        t_ga_priority();
        t_spd();
        t_spd_in_ga();
        t_capture();
        t_hdg_from_appr();
        t_appr_to_ga();
        t_side_back();
        t_ga_after_spd();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule